// File: doc/BRIEF.md
# Macroblock ROI Map Generator

This block builds a per-macroblock quality-control map for a video encoder. Software or a controlling sequencer gives it the frame size in pixels, a region count and up to eight rectangular regions, each carrying a force-intra flag, an area index, a QP value and an absolute/relative mode bit. After a start pulse the block writes the map, one entry per clock, into a small on-chip memory through a plain write port.

The sequence has three phases. First the whole padded map is cleared to a default entry. Then the frame size, the region count and every region are checked together. If anything is illegal, the error flag is raised and no region is written. Otherwise the regions are applied in list order. Each region is snapped to the 16x16 macroblock grid and clipped to the frame, and a later region overwrites earlier entries where two regions overlap. A one-cycle done pulse ends the sequence whether or not it succeeded.

Top module: `roi_map_gen`

## Requirements
- R1: The macroblock count per axis is ceil(pixels/16). The row stride is the macroblock width rounded up to a multiple of 4. The clear phase writes every address from 0 to stride × padded-rows − 1, where padded-rows is the macroblock height rounded up to a multiple of 4.
- R2: The default entry is 16'h0040. Force-intra is 0, the area index is 0, area-enable is 1, the QP adjust is 0 and the mode is relative.
- R3: A region covers columns from x/16 (rounded down) for ceil(w/16) columns, with the end clipped to the macroblock width. Rows follow the same rule with y, h and the height. A region of zero width or zero height writes nothing.
- R4: A region entry packs force-intra in bit 0, reserved zeros in bits 2:1, the area index in bits 5:3, area-enable (1) in bit 6, the QP value in bits 14:7 and the mode bit in bit 15. Mode 1 means absolute.
- R5: Regions are written in list order, so a later region's entry wins at every overlapping address.
- R6: A region with x+w greater than the frame width, or y+h greater than the frame height, is an error.
- R7: A force-intra value above 1, a mode value above 1, or an area index of 8 or more is an error.
- R8: In absolute mode a QP above 51 is an error (negative values are allowed). In relative mode a QP outside −51..+51 is an error.
- R9: A region count above 8, or a frame width or height of zero or less, is an error. A non-positive size clears nothing. A count above 8 still gets the full clear first.
- R10: On any error, err is set and no region entry is written. The clear phase still runs.
- R11: The write address is row × stride + column. Clear and region writes issue one entry per clock while busy.
- R12: done is high for exactly one cycle at the end of every sequence. err is valid with done and holds until the next start. After reset, busy, done, wr_en and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a sequence when idle |
| frame_w | input | 13 | Frame width in pixels, signed |
| frame_h | input | 13 | Frame height in pixels, signed |
| region_cnt | input | 4 | Number of regions in the list |
| rg_x | input | 8×12 | Region left edge in pixels |
| rg_y | input | 8×12 | Region top edge in pixels |
| rg_w | input | 8×12 | Region width in pixels |
| rg_h | input | 8×12 | Region height in pixels |
| rg_intra | input | 8×2 | Force-intra request |
| rg_abs | input | 8×2 | QP mode, 1 = absolute, 0 = relative |
| rg_area | input | 8×4 | Area index |
| rg_qp | input | 8×8 | QP value, signed |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Configuration error of the last sequence |
| wr_en | output | 1 | Map write strobe |
| wr_addr | output | 16 | Map write address |
| wr_data | output | 16 | Map entry |

## Verification
The assertions assume that the frame size, the region count and all region fields stay stable from start until done. The range check on the write address and the in-grid check on region writes are computed from those live inputs. The bench changes inputs only while the block is idle, and it gives random frames of at most 240 pixels so that the whole map fits its shadow memory. Random regions are drawn inside the frame with legal fields, and some of them have one field corrupted on purpose. Directed cases place values exactly on each validity limit and one step past it.

// File: rtl/roi_map_pkg.sv
package roi_map_pkg;

    localparam int QP_LIMIT = 51;

    // Map entry, LSB first: force_intra, rsvd[1:0], area_idx[2:0], area_en, qp_adj[7:0], abs_mode
    typedef struct packed {
        logic       abs_mode;
        logic [7:0] qp_adj;
        logic       area_en;
        logic [2:0] area_idx;
        logic [1:0] rsvd;
        logic       force_intra;
    } roi_entry_t;

    localparam roi_entry_t ENTRY_DEFAULT = '{
        abs_mode: 1'b0, qp_adj: 8'd0, area_en: 1'b1,
        area_idx: 3'd0, rsvd: 2'b00, force_intra: 1'b0
    };

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_CHECK,
        ST_SETUP,
        ST_WRITE,
        ST_DONE
    } seq_state_t;

    function automatic roi_entry_t make_entry(logic intra, logic absm,
                                              logic [2:0] area, logic [7:0] qp);
        roi_entry_t e;
        e.force_intra = intra;
        e.rsvd        = 2'b00;
        e.area_idx    = area;
        e.area_en     = 1'b1;
        e.qp_adj      = qp;
        e.abs_mode    = absm;
        return e;
    endfunction

endpackage

// File: rtl/roi_region_check.sv
module roi_region_check #(
    parameter int PIX_W = 12
) (
    input  logic [PIX_W-1:0] frame_w_u,
    input  logic [PIX_W-1:0] frame_h_u,
    input  logic [PIX_W-1:0] x,
    input  logic [PIX_W-1:0] y,
    input  logic [PIX_W-1:0] w,
    input  logic [PIX_W-1:0] h,
    input  logic [1:0]       intra,
    input  logic [1:0]       absm,
    input  logic [3:0]       area,
    input  logic [7:0]       qp,
    output logic             ok
);
    import roi_map_pkg::*;

    logic [PIX_W:0] x_end;
    logic [PIX_W:0] y_end;
    logic           geom_ok;
    logic           field_ok;
    logic           qp_ok;
    logic signed [7:0] qp_s;

    always_comb begin
        x_end    = {1'b0, x} + {1'b0, w};
        y_end    = {1'b0, y} + {1'b0, h};
        geom_ok  = (x_end <= {1'b0, frame_w_u}) && (y_end <= {1'b0, frame_h_u});
        field_ok = (intra <= 2'd1) && (absm <= 2'd1) && (area < 4'd8);
        qp_s     = $signed(qp);
        if (absm == 2'd1)
            qp_ok = (qp_s <= 8'(QP_LIMIT));
        else
            qp_ok = (qp_s <= 8'(QP_LIMIT)) && (qp_s >= -8'(QP_LIMIT));
        ok = geom_ok && field_ok && qp_ok;
    end

endmodule

// File: rtl/roi_rect_clip.sv
module roi_rect_clip #(
    parameter int PIX_W = 12,
    parameter int MB_W  = PIX_W - 3
) (
    input  logic [PIX_W-1:0] x,
    input  logic [PIX_W-1:0] y,
    input  logic [PIX_W-1:0] w,
    input  logic [PIX_W-1:0] h,
    input  logic [MB_W-1:0]  mb_w,
    input  logic [MB_W-1:0]  mb_h,
    output logic [MB_W-1:0]  col_s,
    output logic [MB_W-1:0]  col_e,
    output logic [MB_W-1:0]  row_s,
    output logic [MB_W-1:0]  row_e,
    output logic             nonempty
);
    logic [MB_W-1:0] ncol;
    logic [MB_W-1:0] nrow;
    logic [MB_W:0]   col_sum;
    logic [MB_W:0]   row_sum;

    always_comb begin
        col_s   = MB_W'(x >> 4);
        row_s   = MB_W'(y >> 4);
        ncol    = MB_W'(({1'b0, w} + (PIX_W+1)'(15)) >> 4);
        nrow    = MB_W'(({1'b0, h} + (PIX_W+1)'(15)) >> 4);
        col_sum = {1'b0, col_s} + {1'b0, ncol};
        row_sum = {1'b0, row_s} + {1'b0, nrow};
        col_e   = (col_sum > {1'b0, mb_w}) ? mb_w : MB_W'(col_sum);
        row_e   = (row_sum > {1'b0, mb_h}) ? mb_h : MB_W'(row_sum);
        nonempty = (col_e > col_s) && (row_e > row_s);
    end

endmodule

// File: rtl/roi_map_gen.sv
module roi_map_gen #(
    parameter int NREG  = 8,
    parameter int PIX_W = 12,
    parameter int CNT_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic signed [PIX_W:0]      frame_w,
    input  logic signed [PIX_W:0]      frame_h,
    input  logic [CNT_W-1:0]           region_cnt,
    input  logic [NREG-1:0][PIX_W-1:0] rg_x,
    input  logic [NREG-1:0][PIX_W-1:0] rg_y,
    input  logic [NREG-1:0][PIX_W-1:0] rg_w,
    input  logic [NREG-1:0][PIX_W-1:0] rg_h,
    input  logic [NREG-1:0][1:0]       rg_intra,
    input  logic [NREG-1:0][1:0]       rg_abs,
    input  logic [NREG-1:0][3:0]       rg_area,
    input  logic [NREG-1:0][7:0]       rg_qp,
    output logic                       busy,
    output logic                       done,
    output logic                       err,
    output logic                       wr_en,
    output logic [2*(PIX_W-4)-1:0]     wr_addr,
    output logic [15:0]                wr_data
);
    import roi_map_pkg::*;

    localparam int MB_W   = PIX_W - 3;
    localparam int ADDR_W = 2 * (PIX_W - 4);
    localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1;

    // frame geometry in macroblocks
    logic             fw_pos, fh_pos;
    logic [MB_W-1:0]  mb_w, mb_h, stride, rows_pad;
    logic [PIX_W:0]   fw_sum, fh_sum;

    always_comb begin
        fw_pos   = (frame_w > 0);
        fh_pos   = (frame_h > 0);
        fw_sum   = {1'b0, frame_w[PIX_W-1:0]} + (PIX_W+1)'(15);
        fh_sum   = {1'b0, frame_h[PIX_W-1:0]} + (PIX_W+1)'(15);
        mb_w     = fw_pos ? MB_W'(fw_sum >> 4) : '0;
        mb_h     = fh_pos ? MB_W'(fh_sum >> 4) : '0;
        stride   = (mb_w + MB_W'(3)) & ~MB_W'(3);
        rows_pad = (mb_h + MB_W'(3)) & ~MB_W'(3);
    end

    // parallel validation of every listed region
    logic [NREG-1:0] reg_ok;
    logic [NREG-1:0] reg_pass;
    logic            all_ok;

    for (genvar i = 0; i < NREG; i++) begin : g_chk
        roi_region_check #(.PIX_W(PIX_W)) u_chk (
            .frame_w_u (frame_w[PIX_W-1:0]),
            .frame_h_u (frame_h[PIX_W-1:0]),
            .x         (rg_x[i]),
            .y         (rg_y[i]),
            .w         (rg_w[i]),
            .h         (rg_h[i]),
            .intra     (rg_intra[i]),
            .absm      (rg_abs[i]),
            .area      (rg_area[i]),
            .qp        (rg_qp[i]),
            .ok        (reg_ok[i])
        );
        assign reg_pass[i] = (CNT_W'(i) < region_cnt) ? reg_ok[i] : 1'b1;
    end

    logic cfg_bad;
    always_comb begin
        all_ok  = &reg_pass;
        cfg_bad = !fw_pos || !fh_pos || (region_cnt > CNT_W'(NREG)) || !all_ok;
    end

    // selected region and its grid rectangle
    logic [IDX_W-1:0] idx;
    logic [MB_W-1:0]  col_s, col_e, row_s, row_e;
    logic             rect_nonempty;
    roi_entry_t       sel_entry;

    roi_rect_clip #(.PIX_W(PIX_W), .MB_W(MB_W)) u_clip (
        .x        (rg_x[idx]),
        .y        (rg_y[idx]),
        .w        (rg_w[idx]),
        .h        (rg_h[idx]),
        .mb_w     (mb_w),
        .mb_h     (mb_h),
        .col_s    (col_s),
        .col_e    (col_e),
        .row_s    (row_s),
        .row_e    (row_e),
        .nonempty (rect_nonempty)
    );

    always_comb begin
        sel_entry = make_entry(rg_intra[idx][0], rg_abs[idx][0],
                               rg_area[idx][2:0], rg_qp[idx]);
    end

    // sequencer
    seq_state_t      state;
    logic [MB_W-1:0] row, col;
    logic            last_reg;

    always_comb begin
        last_reg = ((CNT_W'(idx) + CNT_W'(1)) == region_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            row   <= '0;
            col   <= '0;
            idx   <= '0;
            err   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        err   <= 1'b0;
                        row   <= '0;
                        col   <= '0;
                        idx   <= '0;
                        state <= (stride != '0 && rows_pad != '0) ? ST_CLEAR : ST_CHECK;
                    end
                end
                ST_CLEAR: begin
                    if (col == stride - MB_W'(1)) begin
                        col <= '0;
                        if (row == rows_pad - MB_W'(1)) state <= ST_CHECK;
                        else                            row   <= row + MB_W'(1);
                    end else begin
                        col <= col + MB_W'(1);
                    end
                end
                ST_CHECK: begin
                    if (cfg_bad) begin
                        err   <= 1'b1;
                        state <= ST_DONE;
                    end else if (region_cnt == '0) begin
                        state <= ST_DONE;
                    end else begin
                        idx   <= '0;
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (rect_nonempty) begin
                        row   <= row_s;
                        col   <= col_s;
                        state <= ST_WRITE;
                    end else if (last_reg) begin
                        state <= ST_DONE;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                ST_WRITE: begin
                    if (col == col_e - MB_W'(1)) begin
                        col <= col_s;
                        if (row == row_e - MB_W'(1)) begin
                            if (last_reg) begin
                                state <= ST_DONE;
                            end else begin
                                idx   <= idx + IDX_W'(1);
                                state <= ST_SETUP;
                            end
                        end else begin
                            row <= row + MB_W'(1);
                        end
                    end else begin
                        col <= col + MB_W'(1);
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // write port
    logic [ADDR_W-1:0] row_x, col_x, stride_x;
    logic [ADDR_W:0]   map_size;

    always_comb begin
        row_x    = ADDR_W'(row);
        col_x    = ADDR_W'(col);
        stride_x = ADDR_W'(stride);
        map_size = (ADDR_W+1)'(stride) * (ADDR_W+1)'(rows_pad);
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        wr_en    = (state == ST_CLEAR) || (state == ST_WRITE);
        wr_addr  = row_x * stride_x + col_x;
        wr_data  = (state == ST_CLEAR) ? ENTRY_DEFAULT : sel_entry;
    end

    // assertions
    a_r12_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r12_done_while_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r11_addr_in_map: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ({1'b0, wr_addr} < map_size));

    a_r10_no_write_after_err: assert property (@(posedge clk) disable iff (rst)
        err |-> !wr_en);

    a_r3_write_inside_grid: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE) |-> (col < mb_w && row < mb_h));

    a_r7_written_fields_legal: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE) |-> (rg_area[idx] < 4'd8 && rg_intra[idx] <= 2'd1
                                 && rg_abs[idx] <= 2'd1));

    a_r8_written_qp_legal: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE) |-> ($signed(rg_qp[idx]) <= 8'sd51));

endmodule

// File: tb/test_roi_map_gen.sv
module test_roi_map_gen;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic signed [12:0] frame_w = '0;
    logic signed [12:0] frame_h = '0;
    logic [3:0]        region_cnt = '0;
    logic [7:0][11:0]  rg_x = '0, rg_y = '0, rg_w = '0, rg_h = '0;
    logic [7:0][1:0]   rg_intra = '0, rg_abs = '0;
    logic [7:0][3:0]   rg_area = '0;
    logic [7:0][7:0]   rg_qp = '0;
    logic              busy, done, err, wr_en;
    logic [15:0]       wr_addr, wr_data;

    int checks = 0;
    int errors = 0;

    logic [15:0] got_map [0:1023];
    logic [15:0] exp_map [0:1023];
    int          wr_count;
    int          oob_count;

    always #10 clk = ~clk;

    roi_map_gen i_roi_map_gen (
        .clk(clk), .rst(rst), .start(start),
        .frame_w(frame_w), .frame_h(frame_h), .region_cnt(region_cnt),
        .rg_x(rg_x), .rg_y(rg_y), .rg_w(rg_w), .rg_h(rg_h),
        .rg_intra(rg_intra), .rg_abs(rg_abs), .rg_area(rg_area), .rg_qp(rg_qp),
        .busy(busy), .done(done), .err(err),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // shadow memory of the map
    always @(negedge clk) begin
        if (wr_en) begin
            wr_count++;
            if (wr_addr < 16'd1024) got_map[wr_addr] = wr_data;
            else                    oob_count++;
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_reg(int i, int x, int y, int w, int h,
                           int intra, int absm, int area, int qp);
        rg_x[i] = 12'(x); rg_y[i] = 12'(y); rg_w[i] = 12'(w); rg_h[i] = 12'(h);
        rg_intra[i] = 2'(intra); rg_abs[i] = 2'(absm);
        rg_area[i] = 4'(area); rg_qp[i] = 8'(qp);
    endtask

    function automatic bit region_valid(int i, int fw, int fh);
        int qp;
        qp = $signed(rg_qp[i]);
        if (int'(rg_x[i]) + int'(rg_w[i]) > fw) return 0;
        if (int'(rg_y[i]) + int'(rg_h[i]) > fh) return 0;
        if (rg_intra[i] > 1 || rg_abs[i] > 1 || rg_area[i] >= 8) return 0;
        if (rg_abs[i] == 1) return qp <= 51;
        return (qp <= 51) && (qp >= -51);
    endfunction

    function automatic int ceil16(int v);
        return (v + 15) / 16;
    endfunction

    // builds exp_map, returns expected error; exp_writes by reference
    function automatic bit model(output int exp_writes, output int map_n);
        int fw, fh, mbw, mbh, stride, rows;
        bit bad;
        fw = frame_w; fh = frame_h;
        mbw = (fw > 0) ? ceil16(fw) : 0;
        mbh = (fh > 0) ? ceil16(fh) : 0;
        stride = (mbw + 3) / 4 * 4;
        rows   = (mbh + 3) / 4 * 4;
        map_n  = stride * rows;
        exp_writes = map_n;
        for (int a = 0; a < 1024; a++) exp_map[a] = 16'hFFFF;
        for (int a = 0; a < map_n; a++) exp_map[a] = 16'h0040;
        bad = (fw <= 0) || (fh <= 0) || (region_cnt > 8);
        for (int i = 0; i < 8; i++)
            if (i < int'(region_cnt) && !region_valid(i, fw, fh)) bad = 1;
        if (bad) return 1;
        for (int i = 0; i < int'(region_cnt); i++) begin
            int cs, ce, rs, re;
            logic [15:0] ent;
            cs = rg_x[i] / 16; ce = cs + ceil16(rg_w[i]); if (ce > mbw) ce = mbw;
            rs = rg_y[i] / 16; re = rs + ceil16(rg_h[i]); if (re > mbh) re = mbh;
            ent = {rg_abs[i][0], rg_qp[i], 1'b1, rg_area[i][2:0], 2'b00, rg_intra[i][0]};
            for (int r = rs; r < re; r++)
                for (int c = cs; c < ce; c++) begin
                    exp_map[r * stride + c] = ent;
                    exp_writes++;
                end
        end
        return 0;
    endfunction

    task automatic run_case(string tag);
        int  wait_cyc;
        int  exp_writes, map_n, bad_at;
        bit  exp_err;
        for (int a = 0; a < 1024; a++) got_map[a] = 16'hFFFF;
        wr_count = 0; oob_count = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cyc = 0;
        while (!done && wait_cyc < 5000) begin
            @(negedge clk);
            wait_cyc++;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL R12 %s: done never seen, actual 0 expected 1", tag);
            return;
        end
        exp_err = model(exp_writes, map_n);
        check(tag, "err flag", int'(err), int'(exp_err));
        check("R11", "write count", wr_count, exp_writes);
        check("R11", "out-of-range writes", oob_count, 0);
        bad_at = -1;
        for (int a = 0; a < 1024; a++)
            if (bad_at < 0 && got_map[a] !== exp_map[a]) bad_at = a;
        if (bad_at >= 0)
            check(tag, $sformatf("map entry %0d", bad_at), int'(got_map[bad_at]), int'(exp_map[bad_at]));
        else
            check(tag, "map contents", 0, 0);
        @(negedge clk);
        check("R12", "done after pulse", int'(done), 0);
        check("R12", "err held", int'(err), int'(exp_err));
    endtask

    task automatic clear_regions();
        for (int i = 0; i < 8; i++) set_reg(i, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12", "reset busy", int'(busy), 0);
        check("R12", "reset done", int'(done), 0);
        check("R12", "reset wr_en", int'(wr_en), 0);
        check("R12", "reset err", int'(err), 0);

        // R1/R2: odd frame, no regions: mb 2x3, stride 4, rows 4
        clear_regions(); frame_w = 17; frame_h = 33; region_cnt = 0;
        run_case("R1");
        frame_w = 64; frame_h = 64; run_case("R2");

        // R3/R4: single region, partial macroblocks
        region_cnt = 1;
        set_reg(0, 16, 16, 20, 5, 1, 1, 5, 30);
        frame_w = 64; frame_h = 48; run_case("R3");
        set_reg(0, 3, 0, 60, 48, 0, 0, 7, -20); run_case("R4");
        set_reg(0, 32, 16, 0, 16, 1, 0, 2, 4); run_case("R3");

        // R5: overlap, later wins
        region_cnt = 3;
        set_reg(0, 0, 0, 64, 48, 0, 0, 1, 10);
        set_reg(1, 16, 16, 32, 16, 1, 1, 2, 40);
        set_reg(2, 32, 0, 32, 32, 0, 0, 3, -7);
        run_case("R5");

        // R6: geometry on and past the edge
        region_cnt = 1;
        set_reg(0, 40, 30, 24, 18, 0, 0, 0, 0); run_case("R6");
        set_reg(0, 40, 30, 25, 18, 0, 0, 0, 0); run_case("R6");
        set_reg(0, 40, 30, 24, 19, 0, 0, 0, 0); run_case("R6");

        // R7: field limits
        set_reg(0, 0, 0, 16, 16, 2, 0, 0, 0); run_case("R7");
        set_reg(0, 0, 0, 16, 16, 0, 2, 0, 0); run_case("R7");
        set_reg(0, 0, 0, 16, 16, 0, 0, 8, 0); run_case("R7");
        set_reg(0, 0, 0, 16, 16, 0, 0, 7, 0); run_case("R7");

        // R8: QP limits
        set_reg(0, 0, 0, 16, 16, 0, 1, 0, 51);  run_case("R8");
        set_reg(0, 0, 0, 16, 16, 0, 1, 0, 52);  run_case("R8");
        set_reg(0, 0, 0, 16, 16, 0, 1, 0, -60); run_case("R8");
        set_reg(0, 0, 0, 16, 16, 0, 0, 0, -51); run_case("R8");
        set_reg(0, 0, 0, 16, 16, 0, 0, 0, -52); run_case("R8");

        // R9/R10: bad count and size
        set_reg(0, 0, 0, 16, 16, 1, 0, 1, 5);
        region_cnt = 9; run_case("R9");
        region_cnt = 1; frame_w = 0;  run_case("R9");
        frame_w = 64; frame_h = -5;   run_case("R9");
        frame_h = 48; region_cnt = 2;
        set_reg(1, 0, 0, 16, 16, 0, 0, 9, 0); run_case("R10");

        // constrained random
        for (int n = 0; n < 40; n++) begin
            int fw, fh;
            fw = 1 + $urandom % 240; fh = 1 + $urandom % 240;
            frame_w = 13'(fw); frame_h = 13'(fh);
            region_cnt = 4'($urandom % 9);
            for (int i = 0; i < 8; i++) begin
                int x, y, w, h;
                x = $urandom % fw; y = $urandom % fh;
                w = $urandom % (fw - x + 1); h = $urandom % (fh - y + 1);
                set_reg(i, x, y, w, h, $urandom % 2, $urandom % 2, $urandom % 8,
                        int'($urandom % 103) - 51);
                if ($urandom % 12 == 0) rg_area[i] = 4'd8 + 4'($urandom % 8);
                if ($urandom % 12 == 0) rg_qp[i] = 8'(52 + $urandom % 20);
            end
            run_case("R11");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule